// File: doc/BRIEF.md
# Host Transmit Holding Buffer with Interrupt

This block takes bytes from a host over a small register bus and sends them out as a serial bit stream. It has a holding stage that can be one byte deep, or a small FIFO. A serializer takes the next queued byte whenever a bit-rate strobe calls for it and shifts it out least significant bit first. When nothing is queued the line sits at mark (logic 1).

A status unit tells the host when it may write again. It can raise an interrupt for this, and the host write that refills the buffer withdraws that interrupt. In FIFO mode the "empty" status bit has one of two meanings, chosen by a control bit: either the FIFO has fully drained, or there is still room for another byte. Each byte carries an end-of-frame tag, taken from a control bit at the moment the byte is written. The serializer flags the final bit of a tagged byte. A transmit mode selector may be changed only while the empty condition holds.

Top module: `host_tx_buffer`

## Requirements
- R1: After reset, the status read at 0x1E is 0x08 (empty set, interrupt enable and interrupt-active clear). irq is 0, ser_out is 1, ser_eof is 0, mode_cur is 0 and mode_ok is 0.
- R2: A write to data address 0x10 is accepted only when all of these hold: cts is 1, the request-to-send control bit (bit 0 of 0x11) is 1, and the holding stage has room. Any other data write changes nothing.
- R3: Each byte is sent bit 0 first, one bit per bit_strobe pulse. ser_out changes only in the cycle after a strobe.
- R4: If no byte is queued when the serializer needs the next one, ser_out stays 1 on each following strobe.
- R5: Without FIFO mode the holding stage holds one byte. The empty bit (bit 3 of 0x1E) reads 0 from the cycle after an accepted write, and reads 1 from the cycle after the serializer takes the byte.
- R6: Bit 5 of 0x1E is the interrupt enable and resets to 0. While it is 1, empty becoming true (or the enable being set while empty holds) sets interrupt-active (bit 7 of 0x1E) and irq one cycle later. An accepted data write clears both at the next edge. While the enable is 0, both stay 0.
- R7: FIFO mode (bit 2 of 0x11 set) with the extension bit (bit 3 of 0x11) clear holds 16 bytes. Empty reads 1 only when the FIFO is fully drained.
- R8: FIFO mode with the extension bit set holds 128 bytes. Empty reads 1 whenever at least one more byte fits. A 129th write is refused.
- R9: The end-of-frame bit (bit 1 of 0x11, reset 0) present at write time is stored with the byte. ser_eof is 1 exactly while the last bit of a tagged byte is on ser_out.
- R10: A mode_req pulse loads mode_val into mode_cur and sets mode_ok to 1 only while empty reads 1. Otherwise mode_cur is unchanged and mode_ok becomes 0.
- R11: Reading 0x10 returns 0 and has no side effect. Reads of 0x1E return only bits 7, 5 and 3; all other bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | 8 | Register address |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, combinational from addr |
| cts | input | 1 | Clear-to-send; data writes are refused while low |
| bit_strobe | input | 1 | One-cycle bit-rate enable |
| mode_req | input | 1 | Mode change request pulse |
| mode_val | input | 2 | Requested mode |
| mode_cur | output | 2 | Active mode |
| mode_ok | output | 1 | 1 if the last mode request was accepted |
| ser_out | output | 1 | Serial data, idles at 1 |
| ser_eof | output | 1 | High during the final bit of a tagged byte |
| irq | output | 1 | Interrupt request |

## Verification
Register reads are combinational, so status is sampled one time unit after the address is driven. The effect of a write or a strobe shows up in that sample from the next falling edge, because exactly one register stage lies between either stimulus and the status bits. Interrupt-active and irq lag empty by one further register, so they are read at least two cycles after the strobe that took the byte. Serial bits are queued by the driver as each write is accepted. The monitor compares one queued bit at the falling edge after every strobe, which is the single cycle in which the output register has taken that strobe.

// File: rtl/txb_pkg.sv
package txb_pkg;
  localparam int BYTE_W = 8;

  localparam logic [7:0] ADDR_DATA = 8'h10;
  localparam logic [7:0] ADDR_CTRL = 8'h11;
  localparam logic [7:0] ADDR_STAT = 8'h1E;

  localparam int STAT_EMPTY = 3;
  localparam int STAT_IE    = 5;
  localparam int STAT_IA    = 7;

  localparam int CTRL_RTS  = 0;
  localparam int CTRL_EOF  = 1;
  localparam int CTRL_FIFO = 2;
  localparam int CTRL_EXT  = 3;

  typedef enum logic [1:0] {
    MODE_SYNC   = 2'd0,
    MODE_ASYNC  = 2'd1,
    MODE_FRAMED = 2'd2,
    MODE_RSVD   = 2'd3
  } txmode_e;

  typedef struct packed {
    logic              eof;
    logic [BYTE_W-1:0] data;
  } txb_item_t;
endpackage

// File: rtl/txb_fifo.sv
module txb_fifo
  import txb_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            push,
  input  txb_item_t       push_item,
  input  logic            pop,
  output txb_item_t       head,
  output logic [CW-1:0]   count
);
  txb_item_t       mem [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0]   cnt_q, cnt_d;

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + AW'(1);
    if (pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + AW'(1);
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= push_item;
  end

  assign head  = mem[rd_q];
  assign count = cnt_q;

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH)) |-> !push);
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0));
endmodule

// File: rtl/txb_serializer.sv
module txb_serializer
  import txb_pkg::*;
#(
  localparam int IW = $clog2(BYTE_W)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      strobe,
  input  logic      avail,
  input  txb_item_t head,
  output logic      pop,
  output logic      ser_out,
  output logic      ser_eof
);
  localparam logic [IW-1:0] LAST = IW'(BYTE_W - 1);

  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              tag_q, tag_d;
  logic [IW-1:0]     idx_q, idx_d, nidx;
  logic              busy_q, busy_d;
  logic              ser_q, ser_d;
  logic              eof_q, eof_d;

  assign nidx = idx_q + IW'(1);

  always_comb begin
    sh_d   = sh_q;
    tag_d  = tag_q;
    idx_d  = idx_q;
    busy_d = busy_q;
    ser_d  = ser_q;
    eof_d  = eof_q;
    pop    = 1'b0;
    if (strobe) begin
      if (busy_q && (idx_q != LAST)) begin
        idx_d = nidx;
        ser_d = sh_q[nidx];
        eof_d = tag_q && (nidx == LAST);
      end else if (avail) begin
        pop    = 1'b1;
        sh_d   = head.data;
        tag_d  = head.eof;
        idx_d  = '0;
        busy_d = 1'b1;
        ser_d  = head.data[0];
        eof_d  = 1'b0;
      end else begin
        busy_d = 1'b0;
        ser_d  = 1'b1;
        eof_d  = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      tag_q  <= 1'b0;
      idx_q  <= '0;
      busy_q <= 1'b0;
      ser_q  <= 1'b1;
      eof_q  <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      tag_q  <= tag_d;
      idx_q  <= idx_d;
      busy_q <= busy_d;
      ser_q  <= ser_d;
      eof_q  <= eof_d;
    end
  end

  assign ser_out = ser_q;
  assign ser_eof = eof_q;

  assert_hold_between_strobes_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> ($stable(ser_q) && $stable(eof_q)));
  assert_eof_only_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    eof_q |-> busy_q);
endmodule

// File: rtl/txb_status.sv
module txb_status (
  input  logic clk,
  input  logic rst_n,
  input  logic ie_wr,
  input  logic ie_val,
  input  logic empty,
  input  logic wr_acc,
  output logic ie,
  output logic ia
);
  logic ie_q, ie_d;
  logic ia_q, ia_d;
  logic arm_q, arm_d;
  logic cond;

  always_comb begin
    ie_d  = ie_wr ? ie_val : ie_q;
    cond  = ie_q & empty;
    arm_d = cond;
    if (wr_acc || !ie_d)        ia_d = 1'b0;
    else if (cond && !arm_q)    ia_d = 1'b1;
    else                        ia_d = ia_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q  <= 1'b0;
      ia_q  <= 1'b0;
      arm_q <= 1'b0;
    end else begin
      ie_q  <= ie_d;
      ia_q  <= ia_d;
      arm_q <= arm_d;
    end
  end

  assign ie = ie_q;
  assign ia = ia_q;

  assert_write_clears_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> !ia_q);
  assert_irq_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ia_q |-> ie_q);
endmodule

// File: rtl/host_tx_buffer.sv
module host_tx_buffer
  import txb_pkg::*;
#(
  parameter int DEPTH      = 128,
  parameter int BASE_DEPTH = 16,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cts,
  input  logic       bit_strobe,
  input  logic       mode_req,
  input  logic [1:0] mode_val,
  output logic [1:0] mode_cur,
  output logic       mode_ok,
  output logic       ser_out,
  output logic       ser_eof,
  output logic       irq
);
  logic rts_q, rts_d, eoft_q, eoft_d, fifo_q, fifo_d, ext_q, ext_d;
  txmode_e mode_q, mode_d;
  logic    ok_q, ok_d;

  logic [CW-1:0] count, cap;
  logic          empty, room, wr_acc, pop, ie, ia;
  logic          ctrl_wr, stat_wr;
  txb_item_t     head, push_item;

  assign ctrl_wr = wr_en && (addr == ADDR_CTRL);
  assign stat_wr = wr_en && (addr == ADDR_STAT);

  always_comb begin
    if (!fifo_q)     cap = CW'(1);
    else if (ext_q)  cap = CW'(DEPTH);
    else             cap = CW'(BASE_DEPTH);
    room   = count < cap;
    empty  = (fifo_q && ext_q) ? room : (count == '0);
    wr_acc = wr_en && (addr == ADDR_DATA) && cts && rts_q && room;
    push_item.eof  = eoft_q;
    push_item.data = wdata;
  end

  always_comb begin
    rts_d  = ctrl_wr ? wdata[CTRL_RTS]  : rts_q;
    eoft_d = ctrl_wr ? wdata[CTRL_EOF]  : eoft_q;
    fifo_d = ctrl_wr ? wdata[CTRL_FIFO] : fifo_q;
    ext_d  = ctrl_wr ? wdata[CTRL_EXT]  : ext_q;
    mode_d = mode_q;
    ok_d   = ok_q;
    if (mode_req) begin
      ok_d = empty;
      if (empty) mode_d = txmode_e'(mode_val);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rts_q  <= 1'b0;
      eoft_q <= 1'b0;
      fifo_q <= 1'b0;
      ext_q  <= 1'b0;
      mode_q <= MODE_SYNC;
      ok_q   <= 1'b0;
    end else begin
      rts_q  <= rts_d;
      eoft_q <= eoft_d;
      fifo_q <= fifo_d;
      ext_q  <= ext_d;
      mode_q <= mode_d;
      ok_q   <= ok_d;
    end
  end

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      case (addr)
        ADDR_STAT: begin
          rdata[STAT_EMPTY] = empty;
          rdata[STAT_IE]    = ie;
          rdata[STAT_IA]    = ia;
        end
        ADDR_CTRL: begin
          rdata[CTRL_RTS]  = rts_q;
          rdata[CTRL_EOF]  = eoft_q;
          rdata[CTRL_FIFO] = fifo_q;
          rdata[CTRL_EXT]  = ext_q;
        end
        default: rdata = '0;
      endcase
    end
  end

  txb_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (wr_acc),
    .push_item (push_item),
    .pop       (pop),
    .head      (head),
    .count     (count)
  );

  txb_serializer u_ser (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (bit_strobe),
    .avail   (count != '0),
    .head    (head),
    .pop     (pop),
    .ser_out (ser_out),
    .ser_eof (ser_eof)
  );

  txb_status u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .ie_wr  (stat_wr),
    .ie_val (wdata[STAT_IE]),
    .empty  (empty),
    .wr_acc (wr_acc),
    .ie     (ie),
    .ia     (ia)
  );

  assign mode_cur = mode_q;
  assign mode_ok  = ok_q;
  assign irq      = ia;

  assert_mode_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_req && !empty) |=> ($stable(mode_cur) && !mode_ok));
  assert_refuse_without_cts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cts && !pop) |=> $stable(count));
endmodule

// File: tb/test_host_tx_buffer.sv
module test_host_tx_buffer;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, cts, bit_strobe, mode_req;
  logic [7:0] addr, wdata, rdata;
  logic [1:0] mode_val, mode_cur;
  logic       mode_ok, ser_out, ser_eof, irq;

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_q [$];
  logic       strobe_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_tx_buffer i_host_tx_buffer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cts(cts), .bit_strobe(bit_strobe),
    .mode_req(mode_req), .mode_val(mode_val), .mode_cur(mode_cur),
    .mode_ok(mode_ok), .ser_out(ser_out), .ser_eof(ser_eof), .irq(irq)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // monitor: one expected {eof,bit} per strobe, mark when scoreboard empty (R4)
  always @(posedge clk) strobe_d <= bit_strobe;
  always @(negedge clk) begin
    if (rst_n && strobe_d) begin
      logic [1:0] e;
      e = (exp_q.size() > 0) ? exp_q.pop_front() : 2'b01;
      check("R3/R4/R9 serial", {ser_eof, ser_out}, e);
    end
  end

  task automatic push_byte(logic [7:0] b, logic tag);
    for (int i = 0; i < 8; i++) exp_q.push_back({tag && (i == 7), b[i]});
  endtask

  task automatic bus_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic send(logic [7:0] d, logic tag, logic accepted);
    bus_wr(8'h10, d);
    if (accepted) push_byte(d, tag);
  endtask

  task automatic rd_chk(logic [7:0] a, logic [7:0] exp, string req);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    #1;
    check(req, rdata, exp);
    rd_en = 1'b0;
  endtask

  task automatic strobes(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); bit_strobe = 1'b1;
      @(negedge clk); bit_strobe = 1'b0;
    end
  endtask

  task automatic mode_try(logic [1:0] v, logic exp_ok, logic [1:0] exp_mode);
    @(negedge clk); mode_req = 1'b1; mode_val = v;
    @(negedge clk); mode_req = 1'b0;
    check("R10 mode_ok", mode_ok, exp_ok);
    check("R10 mode_cur", mode_cur, exp_mode);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 0; rd_en = 0; addr = 0; wdata = 0;
    cts = 0; bit_strobe = 0; mode_req = 0; mode_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(8'h1E, 8'h08, "R1 status");
    check("R1 irq", irq, 0);
    check("R1 ser_out", ser_out, 1);
    check("R1 ser_eof", ser_eof, 0);
    check("R1 mode", {mode_ok, mode_cur}, 0);
    // R11 data address reads zero
    rd_chk(8'h10, 8'h00, "R11 data read");

    // R2 rts clear: refused; R4 line stays mark
    cts = 1'b1;
    send(8'h11, 0, 0);
    rd_chk(8'h1E, 8'h08, "R2 rts=0 refused");
    strobes(2);
    // R2 cts clear: refused
    bus_wr(8'h11, 8'h01);
    cts = 1'b0;
    send(8'h22, 0, 0);
    rd_chk(8'h1E, 8'h08, "R2 cts=0 refused");
    strobes(1);
    cts = 1'b1;

    // R6 enable while empty raises irq
    bus_wr(8'h1E, 8'h20);
    @(negedge clk);
    rd_chk(8'h1E, 8'hA8, "R6 ia set on enable");
    check("R6 irq", irq, 1);

    // R5/R6 write clears empty, ia, irq
    send(8'hA5, 0, 1);
    rd_chk(8'h1E, 8'h20, "R5 empty cleared");
    check("R6 irq cleared", irq, 0);
    // R2 holding full: second write refused
    send(8'h5A, 0, 0);
    rd_chk(8'h10, 8'h00, "R11 read no side effect");

    // R10 mode change refused while not empty
    mode_try(2'd2, 0, 2'd0);

    strobes(8);
    rd_chk(8'h1E, 8'hA8, "R5/R6 empty and irq after take");
    check("R6 irq after take", irq, 1);
    mode_try(2'd2, 1, 2'd2);

    // R9 tagged byte followed by untagged byte
    bus_wr(8'h11, 8'h03);
    send(8'h3C, 1, 1);
    strobes(1);
    bus_wr(8'h11, 8'h01);
    send(8'h81, 0, 1);
    strobes(19);

    // R6 enable off: no interrupt
    bus_wr(8'h1E, 8'h00);
    rd_chk(8'h1E, 8'h08, "R6 disable clears ia");
    send(8'h55, 0, 1);
    strobes(10);
    rd_chk(8'h1E, 8'h08, "R6 disabled no ia");
    check("R6 irq disabled", irq, 0);

    // R7 FIFO, extension off: 16 deep, empty means drained
    bus_wr(8'h11, 8'h05);
    send(8'h01, 0, 1);
    rd_chk(8'h1E, 8'h00, "R7 not fully empty");
    for (int i = 1; i < 16; i++) send(8'(i * 7 + 1), 0, 1);
    send(8'hFF, 0, 0);
    rd_chk(8'h1E, 8'h00, "R7 full");
    strobes(16 * 8 + 2);
    rd_chk(8'h1E, 8'h08, "R7 drained");

    // R8 FIFO, extension on: 128 deep, empty means room
    bus_wr(8'h11, 8'h0D);
    send(8'hC3, 0, 1);
    rd_chk(8'h1E, 8'h08, "R8 room available");
    for (int i = 1; i < 128; i++) send(8'(i * 13), 0, 1);
    rd_chk(8'h1E, 8'h00, "R8 no room");
    send(8'hEE, 0, 0);
    strobes(128 * 8 + 2);
    rd_chk(8'h1E, 8'h08, "R8 drained");
    rd_chk(8'h11, 8'h0D, "R11 control readback");
    check("R3 scoreboard drained", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule